// File: doc/BRIEF.md
# Buffered-Update Pulse-Width Modulator Channel

This block produces one pulse-width-modulated waveform from a free-running tick counter. A prescaler divides the input clock by a power of two, and the counter advances once per prescaled tick. It wraps when it reaches the programmed period. Each period opens at the inactive level. The output stays inactive while the count is below the duty value and turns active for the rest of the period. The duty value is therefore the length of the inactive part of the period, and the active part lasts period minus duty ticks. A polarity input chooses which pin level counts as active.

The working period and duty can be loaded directly only while the channel is stopped. While it runs, software writes a single staging register and a target select. The staged value is held until the counter wraps, and only then is it copied into the duty or period register. Every wrap produces a one-cycle period-start pulse, and that pulse marks the cycle in which a staged value becomes active. Disabling the channel clears the counter, forces the inactive level and drops any staged value.

Top module: `pwm_buffered_channel`

## Requirements
- R1: The counter advances once every 2^E input clocks. E is the 4-bit prescale input, and any value above 10 is treated as 10.
- R2: Each period runs ticks 0 to period−1. The output is inactive while the tick count is below duty and active from tick duty onward. The first enabled clock only arms the channel and does not count.
- R3: When duty ≥ period and duty ≠ 0, the output is inactive for the whole period. When duty = 0, it is active for the whole period.
- R4: With polarity 0 the active level is 1. With polarity 1 the active level is 0. The inactive level always equals the polarity input.
- R5: A write to the staging register (upd_wr with upd_value) becomes pending. It is applied on the wrap that ends the current period: to duty when upd_sel = 0 and to period when upd_sel = 1. Until then the running values do not change.
- R6: There is only one staging register. A second write before the wrap replaces the first, including its target. A write in the same cycle as a wrap stays pending for the next wrap.
- R7: period_start is high for exactly the one cycle that follows each wrap edge. In that cycle the counter is back at 0 and any pending value is already in use.
- R8: While enable is low, the counter and prescaler are held at 0, the output is at the inactive level, any pending value is discarded and staging writes are ignored.
- R9: cfg_wr loads cfg_period and cfg_duty into the working registers only while enable is low. It has no effect while the channel runs.
- R10: The data width is a parameter: 16 bits by default, with 32 bits also supported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Channel run control |
| prescale | input | 4 | Clock divide exponent, clamped to 10 |
| polarity | input | 1 | Inactive level; the active level is its inverse |
| cfg_wr | input | 1 | Direct load of period and duty (stopped only) |
| cfg_period | input | W | Period value for direct load |
| cfg_duty | input | W | Duty (inactive length) value for direct load |
| upd_wr | input | 1 | Staging register write strobe |
| upd_sel | input | 1 | Staging target: 0 duty, 1 period |
| upd_value | input | W | Staged value |
| pwm_out | output | 1 | PWM waveform |
| period_start | output | 1 | One-cycle pulse after each wrap |

## Verification
A wrong counter or prescaler state shows up at the ports within one period. The edges of pwm_out or the period_start pulse move by at least one input clock. A staged value that is applied too early or too late changes the position of the next active edge or the spacing of the next period_start pulses, and it does so in the period that should have used it. A pending value that survives a disable shows up in the first period after re-enable. The bench model predicts both outputs on every cycle, so any of these faults is caught in the cycle where it first appears.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
    localparam int unsigned MAX_EXP   = 10;
    localparam int unsigned PRE_BITS  = MAX_EXP;

    typedef enum logic {
        TGT_DUTY   = 1'b0,
        TGT_PERIOD = 1'b1
    } upd_target_e;

    function automatic logic [3:0] clamp_exp(input logic [3:0] e);
        return (e > 4'(MAX_EXP)) ? 4'(MAX_EXP) : e;
    endfunction

    function automatic logic [PRE_BITS-1:0] pre_limit(input logic [3:0] e);
        logic [PRE_BITS:0] one_hot;
        one_hot = (PRE_BITS+1)'(1) << clamp_exp(e);
        return PRE_BITS'(one_hot - 1'b1);
    endfunction
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic [3:0] exp_in,
    output logic       tick
);
    logic [PRE_BITS-1:0] pre_cnt;
    logic [PRE_BITS-1:0] limit;

    assign limit = pre_limit(exp_in);
    assign tick  = !clr && (pre_cnt >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr)
            pre_cnt <= '0;
        else if (tick)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + 1'b1;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        (tick && clamp_exp(exp_in) != 4'd0) |=> (!tick || clamp_exp(exp_in) == 4'd0)); // R1
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic         wrap,
    output logic         start
);
    logic [W:0] next_cnt;

    assign next_cnt = {1'b0, cnt} + 1'b1;
    assign wrap     = tick && (next_cnt >= {1'b0, period});

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt   <= '0;
            start <= 1'b0;
        end else begin
            start <= wrap;
            if (wrap)
                cnt <= '0;
            else if (tick)
                cnt <= next_cnt[W-1:0];
        end
    end

    AST_START_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        start |-> (cnt == '0)); // R7
endmodule

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic         wrap,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic         upd_wr,
    input  logic         upd_sel,
    input  logic [W-1:0] upd_value,
    output logic [W-1:0] period_r,
    output logic [W-1:0] duty_r
);
    typedef struct packed {
        logic        valid;
        upd_target_e target;
        logic [W-1:0] value;
    } pending_t;

    pending_t pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= '0;
            period_r <= '0;
            duty_r   <= '0;
        end else if (!enable) begin
            pend <= '0;
            if (cfg_wr) begin
                period_r <= cfg_period;
                duty_r   <= cfg_duty;
            end
        end else begin
            if (wrap && pend.valid) begin
                if (pend.target == TGT_PERIOD)
                    period_r <= pend.value;
                else
                    duty_r <= pend.value;
            end
            if (upd_wr)
                pend <= '{valid: 1'b1, target: upd_target_e'(upd_sel), value: upd_value};
            else if (wrap)
                pend.valid <= 1'b0;
        end
    end

    AST_HOLD_MID_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (enable && !wrap) |=> ($stable(period_r) && $stable(duty_r))); // R5
    AST_PEND_DROPPED: assert property (@(posedge clk) disable iff (rst)
        !enable |=> !pend.valid); // R8
endmodule

// File: rtl/pwm_buffered_channel.sv
module pwm_buffered_channel
    import pwm_pkg::*;
#(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         enable,
    input  logic [3:0]   prescale,
    input  logic         polarity,
    input  logic         cfg_wr,
    input  logic [W-1:0] cfg_period,
    input  logic [W-1:0] cfg_duty,
    input  logic         upd_wr,
    input  logic         upd_sel,
    input  logic [W-1:0] upd_value,
    output logic         pwm_out,
    output logic         period_start
);
    logic         running;
    logic         hold;
    logic         tick;
    logic         wrap;
    logic [W-1:0] cnt;
    logic [W-1:0] period_r;
    logic [W-1:0] duty_r;
    logic         active;

    always_ff @(posedge clk) begin
        if (rst)
            running <= 1'b0;
        else
            running <= enable;
    end

    assign hold = !(enable && running);

    pwm_prescaler u_pre (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold),
        .exp_in (prescale),
        .tick   (tick)
    );

    pwm_counter #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr    (hold),
        .tick   (tick),
        .period (period_r),
        .cnt    (cnt),
        .wrap   (wrap),
        .start  (period_start)
    );

    pwm_shadow_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .wrap       (wrap),
        .cfg_wr     (cfg_wr),
        .cfg_period (cfg_period),
        .cfg_duty   (cfg_duty),
        .upd_wr     (upd_wr),
        .upd_sel    (upd_sel),
        .upd_value  (upd_value),
        .period_r   (period_r),
        .duty_r     (duty_r)
    );

    assign active  = running && (cnt >= duty_r);
    assign pwm_out = active ^ polarity;

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (rst)
        !running |-> (pwm_out == polarity)); // R8
    AST_OPENS_INACTIVE: assert property (@(posedge clk) disable iff (rst)
        (period_start && duty_r != '0) |-> (pwm_out == polarity)); // R2
    AST_DUTY_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (running && duty_r != '0 && duty_r >= period_r) |-> (pwm_out == polarity)); // R3
endmodule

// File: tb/pwm_buffered_channel_test.sv
`timescale 1ns/1ps
module pwm_buffered_channel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        enable = 1'b0;
    logic [3:0]  prescale = 4'd0;
    logic        polarity = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [15:0] cfg_period = '0;
    logic [15:0] cfg_duty = '0;
    logic        upd_wr = 1'b0;
    logic        upd_sel = 1'b0;
    logic [15:0] upd_value = '0;
    logic        pwm_out, period_start;
    logic        pwm_out_w, period_start_w;

    int vectors = 0;
    int fails = 0;
    string req = "R2";
    bit done = 0;

    always #2 clk = ~clk;

    pwm_buffered_channel #(.W(16)) uut (
        .clk(clk), .rst(rst), .enable(enable), .prescale(prescale),
        .polarity(polarity), .cfg_wr(cfg_wr), .cfg_period(cfg_period),
        .cfg_duty(cfg_duty), .upd_wr(upd_wr), .upd_sel(upd_sel),
        .upd_value(upd_value), .pwm_out(pwm_out), .period_start(period_start)
    );

    pwm_buffered_channel #(.W(32)) uut_wide (
        .clk(clk), .rst(rst), .enable(enable), .prescale(prescale),
        .polarity(polarity), .cfg_wr(cfg_wr), .cfg_period({16'd0, cfg_period}),
        .cfg_duty({16'd0, cfg_duty}), .upd_wr(upd_wr), .upd_sel(upd_sel),
        .upd_value({16'd0, upd_value}), .pwm_out(pwm_out_w), .period_start(period_start_w)
    );

    // behavioural reference
    int  m_pre, m_cnt, m_per, m_dty, m_pval;
    bit  m_pv, m_ps, m_run, m_start;

    always @(posedge clk) begin
        int e;
        bit tk;
        if (rst) begin
            m_pre = 0; m_cnt = 0; m_per = 0; m_dty = 0;
            m_pv = 0; m_ps = 0; m_pval = 0; m_run = 0; m_start = 0;
        end else if (!enable) begin
            m_pre = 0; m_cnt = 0; m_pv = 0; m_run = 0; m_start = 0;
            if (cfg_wr) begin m_per = cfg_period; m_dty = cfg_duty; end
        end else if (!m_run) begin
            m_run = 1; m_start = 0;
            if (upd_wr) begin m_pv = 1; m_ps = upd_sel; m_pval = upd_value; end
        end else begin
            e  = (prescale > 10) ? 10 : prescale;
            tk = (m_pre >= (1 << e) - 1);
            m_start = 0;
            if (tk) begin
                m_pre = 0;
                if (m_cnt + 1 >= m_per) begin
                    m_cnt = 0;
                    m_start = 1;
                    if (m_pv) begin
                        if (m_ps) m_per = m_pval; else m_dty = m_pval;
                        m_pv = 0;
                    end
                end else m_cnt++;
            end else m_pre++;
            if (upd_wr) begin m_pv = 1; m_ps = upd_sel; m_pval = upd_value; end
        end
    end

    always @(negedge clk) begin
        bit exp_w;
        if (!rst && !done) begin
            exp_w = (m_run && m_cnt >= m_dty) ^ polarity;
            vectors++;
            if (pwm_out !== exp_w || period_start !== m_start) begin
                fails++;
                $display("FAIL %s: out=%b start=%b expected out=%b start=%b", req,
                         pwm_out, period_start, exp_w, m_start);
            end
            vectors++;
            if (pwm_out_w !== exp_w || period_start_w !== m_start) begin
                fails++;
                $display("FAIL R10: wide out=%b start=%b expected out=%b start=%b",
                         pwm_out_w, period_start_w, exp_w, m_start);
            end
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic stage(input bit sel, input int val);
        upd_sel = sel; upd_value = 16'(val); upd_wr = 1'b1;
        cyc(1);
        upd_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog: run hung, actual=timeout expected=finish");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        cyc(1);
        // reset state
        vectors++;
        if (pwm_out !== 1'b0 || period_start !== 1'b0) begin
            fails++;
            $display("FAIL R8: reset out=%b start=%b expected out=0 start=0", pwm_out, period_start);
        end
        req = "R9"; cfg_period = 16'd8; cfg_duty = 16'd3; cfg_wr = 1'b1; cyc(1); cfg_wr = 1'b0;
        req = "R2"; enable = 1'b1; cyc(40);
        req = "R7"; cyc(20);
        req = "R4"; polarity = 1'b1; cyc(30); polarity = 1'b0;
        req = "R1"; prescale = 4'd2; cyc(120);
        prescale = 4'd15; enable = 1'b0; cfg_period = 16'd2; cfg_duty = 16'd1; cfg_wr = 1'b1;
        cyc(1); cfg_wr = 1'b0; enable = 1'b1; cyc(4300);
        prescale = 4'd0; enable = 1'b0; cfg_period = 16'd8; cfg_duty = 16'd3; cfg_wr = 1'b1;
        cyc(1); cfg_wr = 1'b0; enable = 1'b1; cyc(10);
        req = "R5"; stage(1'b0, 6); cyc(30); stage(1'b1, 12); cyc(40);
        prescale = 4'd1; stage(1'b0, 2); cyc(50); prescale = 4'd0;
        req = "R6"; stage(1'b0, 9); stage(1'b1, 5); cyc(30); stage(1'b1, 10); cyc(40);
        req = "R3"; stage(1'b0, 20); cyc(40); stage(1'b0, 10); cyc(30); stage(1'b0, 0); cyc(40);
        req = "R9"; cfg_period = 16'd4; cfg_duty = 16'd1; cfg_wr = 1'b1; cyc(3); cfg_wr = 1'b0; cyc(30);
        req = "R8"; stage(1'b1, 3); enable = 1'b0; cyc(1); stage(1'b0, 7); cyc(5);
        enable = 1'b1; cyc(40);
        req = "R7"; stage(1'b1, 1); cyc(20); stage(1'b1, 0); cyc(10); stage(1'b1, 6); stage(1'b0, 2); cyc(40);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule